// File: doc/BRIEF.md
# Alias Guard Register Unit

This block holds a small bank of address registers that let compiled code validate memory accesses it has reordered. When a store is scheduled after a load that originally followed it, the load can *protect* its address. This records the address and access size in a register chosen by an index. The later store then issues a *check*. The check compares the store's byte range against a set of registers picked by a bit mask. Any overlap raises a registered fault, together with a vector naming every register that overlapped.

One access may protect, check, or do both in the same cycle. When it does both, the comparison sees the bank as it stood before this cycle's write. A clear input drops every record at once, for use when a speculative region commits or rolls back. Handling the fault is left to the surrounding logic.

Top module: `alias_guard_unit`

## Requirements
- R1: After reset every register is empty, and `fault` and `fault_vec` are low.
- R2: A cycle with `prot_en` high and `clear_all` low stores `acc_addr` and `acc_size` into register `prot_sel` and marks that register valid from the next cycle on.
- R3: A cycle with `chk_en` high sets `fault_vec[i]` on the next cycle for every register i that is selected in `chk_sel`, is valid, and overlaps the access. Several bits may be set at once.
- R4: `acc_size` encodes the access length: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Two accesses overlap when their byte ranges [addr, addr+len) share at least one byte, so ranges that only touch do not overlap.
- R5: `fault` is high in exactly the cycles where `fault_vec` is non-zero. Both outputs are zero in the cycle after any cycle in which `chk_en` is low.
- R6: When `chk_en` and `prot_en` are high in the same cycle, the check uses the register contents from before this cycle's protect write.
- R7: `clear_all` makes every register invalid from the next cycle on, and it takes priority over a protect in the same cycle.
- R8: A register that is unselected in `chk_sel`, or that is not valid, never sets its bit in `fault_vec`.
- R9: A protect to a register that already holds a record replaces the old address and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_all | input | 1 | Invalidate every alias register |
| prot_en | input | 1 | Record the access into register `prot_sel` |
| chk_en | input | 1 | Compare the access against the registers in `chk_sel` |
| acc_addr | input | ADDR_W (16) | Byte address of the access |
| acc_size | input | 2 | Access length code (1, 2, 4 or 8 bytes) |
| prot_sel | input | $clog2(NUM_REGS) (3) | Register index written by a protect |
| chk_sel | input | NUM_REGS (8) | Registers included in a check |
| fault | output | 1 | Registered alias fault |
| fault_vec | output | NUM_REGS (8) | Registered mask of the registers that overlapped |

## Verification
The assertions check the following on every cycle:
- that a protect leaves the target register valid with the written address and size;
- that a clear empties the registers;
- that fault bits never appear outside the selected mask or without a check in the cycle before;
- that `fault` agrees with `fault_vec`.

The overlap arithmetic needs directed scenarios from the bench, because only a scenario can show it exactly: ranges that share a byte against ranges that only touch, across every size. Scenarios are also needed for the read-before-write ordering when one access both checks and protects, for the replacement of an old record, and for clear winning over a protect in the same cycle.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;

   typedef logic [1:0] acc_size_t;

   // access length in bytes for a size code
   function automatic logic [3:0] size_bytes(input acc_size_t code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/alias_slot.sv
module alias_slot
   import alias_guard_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  acc_size_t         wr_size,
   input  logic [ADDR_W-1:0] q_addr,
   input  acc_size_t         q_size,
   output logic              hit
);
   localparam int EXT_W = ADDR_W + 1;

   logic              valid_q;
   logic [ADDR_W-1:0] base_q;
   acc_size_t         size_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         base_q  <= '0;
         size_q  <= '0;
      end else if (clr) begin
         valid_q <= 1'b0;
      end else if (wr) begin
         valid_q <= 1'b1;
         base_q  <= wr_addr;
         size_q  <= wr_size;
      end
   end

   logic [EXT_W-1:0] s_lo, s_hi, q_lo, q_hi;

   always_comb begin
      s_lo = {1'b0, base_q};
      s_hi = s_lo + EXT_W'(size_bytes(size_q));
      q_lo = {1'b0, q_addr};
      q_hi = q_lo + EXT_W'(size_bytes(q_size));
      hit  = valid_q && (s_lo < q_hi) && (q_lo < s_hi);
   end

   a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !valid_q);

   a_r2_protect_records: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr) |=> (valid_q && base_q == $past(wr_addr) && size_q == $past(wr_size)));

   a_r8_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> !hit);

endmodule

// File: rtl/alias_fault_stage.sv
module alias_fault_stage #(
   parameter int NUM_REGS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                chk_en,
   input  logic [NUM_REGS-1:0] hit_vec,
   input  logic [NUM_REGS-1:0] chk_sel,
   output logic                fault,
   output logic [NUM_REGS-1:0] fault_vec
);
   logic [NUM_REGS-1:0] sel_hits;

   always_comb sel_hits = hit_vec & chk_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault     <= 1'b0;
         fault_vec <= '0;
      end else begin
         fault     <= chk_en && (sel_hits != '0);
         fault_vec <= chk_en ? sel_hits : '0;
      end
   end

   a_r5_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |=> (fault_vec == '0 && !fault));

   a_r3_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |=> ((fault_vec & ~$past(chk_sel)) == '0));

   a_r5_flag_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
      fault == (fault_vec != '0));

endmodule

// File: rtl/alias_guard_unit.sv
module alias_guard_unit
   import alias_guard_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int NUM_REGS = 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_all,
   input  logic                prot_en,
   input  logic                chk_en,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic [1:0]          acc_size,
   input  logic [IDX_W-1:0]    prot_sel,
   input  logic [NUM_REGS-1:0] chk_sel,
   output logic                fault,
   output logic [NUM_REGS-1:0] fault_vec
);
   if (NUM_REGS < 2 || NUM_REGS > 64) begin : g_bad_regs
      $error("alias_guard_unit: NUM_REGS must lie in 2..64");
   end
   if (ADDR_W < 4 || ADDR_W > 63) begin : g_bad_addr
      $error("alias_guard_unit: ADDR_W must lie in 4..63");
   end

   logic [NUM_REGS-1:0] hit_vec;
   logic [NUM_REGS-1:0] wr_vec;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      assign wr_vec[i] = prot_en && (prot_sel == IDX_W'(i));

      alias_slot #(.ADDR_W(ADDR_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clear_all),
         .wr      (wr_vec[i]),
         .wr_addr (acc_addr),
         .wr_size (acc_size_t'(acc_size)),
         .q_addr  (acc_addr),
         .q_size  (acc_size_t'(acc_size)),
         .hit     (hit_vec[i])
      );
   end

   alias_fault_stage #(.NUM_REGS(NUM_REGS)) u_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .chk_en    (chk_en),
      .hit_vec   (hit_vec),
      .chk_sel   (chk_sel),
      .fault     (fault),
      .fault_vec (fault_vec)
   );

   a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_vec));

endmodule

// File: tb/alias_guard_unit_test.sv
`timescale 1ns/1ps
module alias_guard_unit_test;
   localparam int AW = 16;
   localparam int N  = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic clear_all, prot_en, chk_en;
   logic [AW-1:0] acc_addr;
   logic [1:0] acc_size;
   logic [2:0] prot_sel;
   logic [N-1:0] chk_sel;
   logic fault;
   logic [N-1:0] fault_vec;

   always #5 clk = ~clk;

   alias_guard_unit #(.ADDR_W(AW), .NUM_REGS(N)) uut (
      .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .prot_en(prot_en),
      .chk_en(chk_en), .acc_addr(acc_addr), .acc_size(acc_size),
      .prot_sel(prot_sel), .chk_sel(chk_sel), .fault(fault), .fault_vec(fault_vec)
   );

   int errors = 0;
   int checks = 0;

   // reference model state
   bit     m_valid [N];
   int     m_base  [N];
   int     m_len   [N];
   logic [N-1:0] exp_vec;

   task automatic check_out(input string tag);
      checks++;
      if (fault_vec !== exp_vec || fault !== (exp_vec != 0)) begin
         errors++;
         $display("FAIL %s: fault=%b fault_vec=%b expected fault=%b fault_vec=%b",
                  tag, fault, fault_vec, (exp_vec != 0), exp_vec);
      end
   endtask

   // one cycle: drive, predict, clock, compare
   task automatic step(input string tag, input bit clr, input bit prot, input bit chk,
                       input int addr, input int sz, input int idx, input logic [N-1:0] sel);
      int len;
      clear_all = clr; prot_en = prot; chk_en = chk;
      acc_addr = AW'(addr); acc_size = 2'(sz); prot_sel = 3'(idx); chk_sel = sel;
      len = 1 << sz;
      exp_vec = '0;
      if (chk)
         for (int i = 0; i < N; i++)
            if (sel[i] && m_valid[i] && m_base[i] < addr + len && addr < m_base[i] + m_len[i])
               exp_vec[i] = 1'b1;
      if (clr) begin
         for (int i = 0; i < N; i++) m_valid[i] = 0;
      end else if (prot) begin
         m_valid[idx] = 1; m_base[idx] = addr; m_len[idx] = len;
      end
      @(posedge clk); #1;
      check_out(tag);
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, 0, 0, 0, 0, '0);
   endtask

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_base[i] = 0; m_len[i] = 1; end
      rst_n = 0; clear_all = 0; prot_en = 0; chk_en = 0;
      acc_addr = '0; acc_size = '0; prot_sel = '0; chk_sel = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      exp_vec = '0; check_out("R1 reset outputs");
      // R1: all registers empty, so a full check at address 0 reports nothing
      step("R1 empty bank", 0, 0, 1, 0, 3, 0, 8'hFF);

      // R2/R4: protect 8 bytes at 0x100 in register 0
      step("R2 protect", 0, 1, 0, 'h100, 3, 0, '0);
      step("R4 inside", 0, 0, 1, 'h104, 0, 0, 8'hFF);
      idle("R5 fault drops");
      step("R4 touch above", 0, 0, 1, 'h108, 2, 0, 8'hFF);
      step("R4 straddle below", 0, 0, 1, 'h0FF, 1, 0, 8'hFF);
      step("R4 touch below", 0, 0, 1, 'h0FE, 1, 0, 8'hFF);
      step("R4 last byte", 0, 0, 1, 'h107, 0, 0, 8'hFF);

      // R3/R8: register 3 holds 0x200, 2 bytes
      step("R2 protect r3", 0, 1, 0, 'h200, 1, 3, '0);
      step("R8 unselected", 0, 0, 1, 'h201, 0, 0, 8'hF7);
      step("R3 selected", 0, 0, 1, 'h201, 0, 0, 8'h08);
      step("R2 protect r6", 0, 1, 0, 'h1FC, 2, 6, '0);
      step("R3 two hits", 0, 0, 1, 'h1FE, 2, 0, 8'hFF);
      step("R8 invalid r5", 0, 0, 1, 'h1FE, 2, 0, 8'h20);

      // R6: check and protect together on empty register 5
      step("R6 same cycle", 0, 1, 1, 'h400, 2, 5, 8'h20);
      step("R6 after write", 0, 0, 1, 'h402, 0, 0, 8'h20);

      // R9: replace register 0
      step("R9 overwrite", 0, 1, 0, 'h300, 0, 0, '0);
      step("R9 old gone", 0, 0, 1, 'h100, 3, 0, 8'h01);
      step("R9 new held", 0, 0, 1, 'h300, 0, 0, 8'h01);

      // R7: clear wins over protect, check in that cycle sees old state
      step("R7 clear with check", 1, 1, 1, 'h300, 0, 2, 8'hFF);
      step("R7 bank empty", 0, 0, 1, 'h300, 3, 0, 8'hFF);
      step("R7 no protect", 0, 0, 1, 'h1F8, 3, 0, 8'hFF);

      // sweep of sizes against a 4-byte record at 0x800
      step("R2 protect r7", 0, 1, 0, 'h800, 2, 7, '0);
      for (int s = 0; s < 4; s++)
         for (int d = -9; d <= 5; d++)
            step("R4 sweep", 0, 0, 1, 'h800 + d, s, 0, 8'h80);
      idle("R5 idle end");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule